// File: doc/BRIEF.md
# Dual-Issue Decode Pairing Arbiter

This block sits between an instruction queue and a two-way decoder. Each cycle it looks at the two oldest queue entries. Each entry arrives already pre-decoded into a descriptor. The arbiter makes three decisions for the cycle:

- whether the second entry may be decoded in the same cycle as the first;
- which pipe each issued entry is steered to (X or Y);
- whether the decode stage must pay one extra cycle.

The first issued entry always goes to the X pipe. A paired second entry goes to the Y pipe.

Most of the decision is combinational from the descriptors and the queue's valid-byte count. The only state is a single flag. It records that an exclusive instruction has gone down the X pipe and still owns the Y pipe. While the flag is set, nothing issues. The flag clears when the first address-calculation stage reports that it has advanced, or when the pipeline is flushed.

The queue, the length decoder and the execution pipes lie outside the block. They use the two issue bits to pop entries and the penalty bit to stretch decode by one cycle.

Top module: `dual_issue_arbiter`

## Requirements
- R1: After reset the hold flag is clear: `y_block` is 0, and with `q_count` = 0 neither slot issues and `penalty` is 0.
- R2: With `q_count` = 1, slot 0 issues to the X pipe (`s0_pipe_y` = 0) and slot 1 does not issue. A `q_count` of 2 or 3 means two entries are present.
- R3: Slot 1 is not paired when its prefix count is greater than 1.
- R4: Slot 1 is not paired when slot 0 is longer than 6 bytes, or when slot 0 is exactly 6 bytes and slot 1 has any prefix.
- R5: Slot 1 is not paired when `s0_len + s1_len` exceeds `q_bytes`.
- R6: Slot 1 is not paired when slot 0's last byte is 8'h0F and slot 1 has no prefix, or when `s0_pred_taken` is 1.
- R7: Class codes are 0 = other, 1 = jump/call, 2 = set-on-condition, 3 = FPU, 4 = exclusive, and 5 to 7 are treated as other. Slot 1 pairs and goes to the Y pipe (`s1_pipe_y` = 1) only if two entries are present, no rule in R3 to R6 blocks it, its class is 0 or 5 to 7, and slot 0's class is not 4.
- R8: `penalty` is 1 when an issued entry has a prefix count of 2 to 6 inclusive. A count of 0, 1 or 7 adds nothing.
- R9: `penalty` is also 1 when an issued entry has an address-size override together with a displacement, or an operand-size override together with an immediate, or when `s0_len` exceeds `q_bytes` for slot 0.
- R10: A class-4 entry in slot 0 issues alone. `y_block` is 1 in that cycle. From the next cycle, nothing issues and `y_block` stays 1 until the cycle after `ac1_ready` is seen high.
- R11: While `flush` is 1, nothing issues. `flush` also clears the hold flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline flush: suppresses issue and clears the hold |
| ac1_ready | input | 1 | First address-calculation stage advanced |
| q_count | input | 2 | Valid entries in the queue (0, 1, 2 or more) |
| q_bytes | input | QB_W | Valid bytes in the queue |
| s0_len | input | LEN_W | Slot 0 length in bytes |
| s0_pfx | input | PFX_W | Slot 0 prefix count |
| s0_asz | input | 1 | Slot 0 address-size override |
| s0_osz | input | 1 | Slot 0 operand-size override |
| s0_disp | input | 1 | Slot 0 has a displacement |
| s0_imm | input | 1 | Slot 0 has an immediate |
| s0_last_byte | input | 8 | Slot 0 final byte value |
| s0_pred_taken | input | 1 | Slot 0 is a predicted-taken change of flow |
| s0_cls | input | 3 | Slot 0 class code |
| s1_len | input | LEN_W | Slot 1 length in bytes |
| s1_pfx | input | PFX_W | Slot 1 prefix count |
| s1_asz | input | 1 | Slot 1 address-size override |
| s1_osz | input | 1 | Slot 1 operand-size override |
| s1_disp | input | 1 | Slot 1 has a displacement |
| s1_imm | input | 1 | Slot 1 has an immediate |
| s1_cls | input | 3 | Slot 1 class code |
| s0_issue | output | 1 | Slot 0 decoded this cycle |
| s1_issue | output | 1 | Slot 1 decoded this cycle |
| s0_pipe_y | output | 1 | Slot 0 pipe (0 = X) |
| s1_pipe_y | output | 1 | Slot 1 pipe (1 = Y) |
| penalty | output | 1 | One-cycle decode penalty |
| y_block | output | 1 | Y pipe held by an exclusive entry |

## Verification
The bench builds the block with its default parameters:

- `LEN_W` = 4, so lengths run 1 to 15;
- `PFX_W` = 3, so prefix counts run 0 to 7;
- `QB_W` = 5, so the queue holds up to 31 bytes.

At these widths the bench can cover several ranges completely: every length pair against three queue fills, every prefix count on both slots against every override/displacement/immediate combination, and every pair of class codes. This puts each threshold within reach: six bytes, one prefix, two and six prefixes, and length sum against queue fill. A directed sequence holds `ac1_ready` low for several cycles to observe the exclusive hold, and a second sequence releases the hold with `flush` instead.

// File: rtl/dia_pkg.sv
package dia_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_BRANCH = 3'd1,
    CLS_SETCC  = 3'd2,
    CLS_FPU    = 3'd3,
    CLS_EXCL   = 3'd4
  } iclass_e;

  localparam int unsigned LONG_FIRST = 6;
  localparam int unsigned PFX_PEN_HI = 6;
  localparam logic [7:0]  ESC_BYTE   = 8'h0F;

  // classes that may only use the X pipe
  function automatic logic x_only(logic [2:0] c);
    return (c == CLS_BRANCH) || (c == CLS_SETCC) || (c == CLS_FPU);
  endfunction

  function automatic logic is_excl(logic [2:0] c);
    return c == CLS_EXCL;
  endfunction

  // pair byte budget: both entries must be present in the queue
  function automatic logic pair_fits(int unsigned a, int unsigned b, int unsigned q);
    return (a + b) <= q;
  endfunction

  function automatic logic first_too_long(int unsigned len0, int unsigned pfx1);
    return (len0 > LONG_FIRST) || (len0 == LONG_FIRST && pfx1 != 0);
  endfunction

  function automatic logic slot_cost(int unsigned pfx, logic asz, logic disp,
                                     logic osz, logic imm, logic short_q);
    return (pfx >= 2 && pfx <= PFX_PEN_HI) || (asz && disp) || (osz && imm) || short_q;
  endfunction
endpackage

// File: rtl/dia_pair_rules.sv
module dia_pair_rules #(
  parameter int LEN_W = 4,
  parameter int PFX_W = 3,
  parameter int QB_W  = 5
) (
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  input  logic [PFX_W-1:0] pfx1,
  input  logic [7:0]       last0,
  input  logic             taken0,
  input  logic [2:0]       cls0,
  input  logic [2:0]       cls1,
  input  logic [QB_W-1:0]  qbytes,
  output logic             blk_pfx,
  output logic             blk_len,
  output logic             blk_fit,
  output logic             blk_seq,
  output logic             blk_cls,
  output logic             pair_ok
);
  import dia_pkg::*;

  always_comb begin
    blk_pfx = 32'(pfx1) > 1;
    blk_len = first_too_long(32'(len0), 32'(pfx1));
    blk_fit = !pair_fits(32'(len0), 32'(len1), 32'(qbytes));
    blk_seq = (last0 == ESC_BYTE && pfx1 == '0) || taken0;
    blk_cls = is_excl(cls0) || is_excl(cls1) || x_only(cls1);
    pair_ok = !(blk_pfx || blk_len || blk_fit || blk_seq || blk_cls);
  end
endmodule

// File: rtl/dia_slot_penalty.sv
module dia_slot_penalty #(
  parameter int LEN_W     = 4,
  parameter int PFX_W     = 3,
  parameter int QB_W      = 5,
  parameter bit CHECK_LEN = 1'b1
) (
  input  logic [PFX_W-1:0] pfx,
  input  logic             asz,
  input  logic             osz,
  input  logic             disp,
  input  logic             imm,
  input  logic [LEN_W-1:0] len,
  input  logic [QB_W-1:0]  qbytes,
  output logic             pen
);
  import dia_pkg::*;

  logic short_q;

  generate
    if (CHECK_LEN) begin : g_len
      assign short_q = 32'(len) > 32'(qbytes);
    end else begin : g_nolen
      assign short_q = 1'b0;
    end
  endgenerate

  assign pen = slot_cost(32'(pfx), asz, disp, osz, imm, short_q);
endmodule

// File: rtl/dia_excl_hold.sv
module dia_excl_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hold_q <= 1'b0;
    else if (hold_q && clr)   hold_q <= 1'b0;
    else if (set)             hold_q <= 1'b1;
  end
endmodule

// File: rtl/dual_issue_arbiter.sv
module dual_issue_arbiter #(
  parameter int LEN_W = 4,
  parameter int PFX_W = 3,
  parameter int QB_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ac1_ready,
  input  logic [1:0]       q_count,
  input  logic [QB_W-1:0]  q_bytes,
  input  logic [LEN_W-1:0] s0_len,
  input  logic [PFX_W-1:0] s0_pfx,
  input  logic             s0_asz,
  input  logic             s0_osz,
  input  logic             s0_disp,
  input  logic             s0_imm,
  input  logic [7:0]       s0_last_byte,
  input  logic             s0_pred_taken,
  input  logic [2:0]       s0_cls,
  input  logic [LEN_W-1:0] s1_len,
  input  logic [PFX_W-1:0] s1_pfx,
  input  logic             s1_asz,
  input  logic             s1_osz,
  input  logic             s1_disp,
  input  logic             s1_imm,
  input  logic [2:0]       s1_cls,
  output logic             s0_issue,
  output logic             s1_issue,
  output logic             s0_pipe_y,
  output logic             s1_pipe_y,
  output logic             penalty,
  output logic             y_block
);
  import dia_pkg::*;

  localparam int SLOTS = 2;

  // named internal events (observed by the bound checker)
  logic hold_q;
  logic pair_ok;
  logic excl_issue;
  logic blk_pfx, blk_len, blk_fit, blk_seq, blk_cls;
  logic [SLOTS-1:0] slot_pen;

  logic [PFX_W-1:0] pfx_a  [SLOTS];
  logic [LEN_W-1:0] len_a  [SLOTS];
  logic [SLOTS-1:0] asz_a, osz_a, disp_a, imm_a;

  assign pfx_a[0] = s0_pfx;  assign pfx_a[1] = s1_pfx;
  assign len_a[0] = s0_len;  assign len_a[1] = s1_len;
  assign asz_a  = {s1_asz,  s0_asz};
  assign osz_a  = {s1_osz,  s0_osz};
  assign disp_a = {s1_disp, s0_disp};
  assign imm_a  = {s1_imm,  s0_imm};

  dia_pair_rules #(.LEN_W(LEN_W), .PFX_W(PFX_W), .QB_W(QB_W)) u_rules (
    .len0    (s0_len),
    .len1    (s1_len),
    .pfx1    (s1_pfx),
    .last0   (s0_last_byte),
    .taken0  (s0_pred_taken),
    .cls0    (s0_cls),
    .cls1    (s1_cls),
    .qbytes  (q_bytes),
    .blk_pfx (blk_pfx),
    .blk_len (blk_len),
    .blk_fit (blk_fit),
    .blk_seq (blk_seq),
    .blk_cls (blk_cls),
    .pair_ok (pair_ok)
  );

  // slot 1 is only ever penalised when paired, and pairing already demands
  // that both lengths fit, so the queue-length check lives on slot 0 only
  for (genvar g = 0; g < SLOTS; g++) begin : g_pen
    dia_slot_penalty #(
      .LEN_W(LEN_W), .PFX_W(PFX_W), .QB_W(QB_W), .CHECK_LEN(g == 0)
    ) u_pen (
      .pfx    (pfx_a[g]),
      .asz    (asz_a[g]),
      .osz    (osz_a[g]),
      .disp   (disp_a[g]),
      .imm    (imm_a[g]),
      .len    (len_a[g]),
      .qbytes (q_bytes),
      .pen    (slot_pen[g])
    );
  end

  logic active;
  logic have_one, have_two;

  always_comb begin
    active     = !hold_q && !flush;
    have_one   = q_count != 2'd0;
    have_two   = q_count >= 2'd2;
    s0_issue   = active && have_one;
    s1_issue   = s0_issue && have_two && pair_ok;
    excl_issue = s0_issue && is_excl(s0_cls);
    s0_pipe_y  = 1'b0;
    s1_pipe_y  = s1_issue;
    penalty    = (s0_issue && slot_pen[0]) || (s1_issue && slot_pen[1]);
    y_block    = hold_q || excl_issue;
  end

  dia_excl_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (excl_issue),
    .clr    (ac1_ready || flush),
    .hold_q (hold_q)
  );
endmodule

// File: rtl/dia_chk.sv
module dia_chk #(
  parameter int LEN_W = 4,
  parameter int PFX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             ac1_ready,
  input logic [1:0]       q_count,
  input logic [LEN_W-1:0] s0_len,
  input logic [PFX_W-1:0] s1_pfx,
  input logic [2:0]       s0_cls,
  input logic [2:0]       s1_cls,
  input logic             s0_issue,
  input logic             s1_issue,
  input logic             s1_pipe_y,
  input logic             penalty,
  input logic             y_block,
  input logic             hold_q
);
  // R1
  empty_queue_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == 2'd0) |-> (!s0_issue && !s1_issue && !penalty));

  // R2
  slot1_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> (s0_issue && q_count >= 2'd2));

  // R3
  pfx_pair_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> (s1_pfx <= PFX_W'(1)));

  // R4
  long_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> (s0_len <= LEN_W'(6)));

  // R7
  y_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> (s1_pipe_y && s1_cls != 3'd1 && s1_cls != 3'd2 &&
                  s1_cls != 3'd3 && s1_cls != 3'd4 && s0_cls != 3'd4));

  // R10
  excl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_issue && s0_cls == 3'd4) |=> (y_block && !s0_issue));

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && (ac1_ready || flush)) |=> !hold_q);

  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!s0_issue && !s1_issue));
endmodule

bind dual_issue_arbiter dia_chk #(.LEN_W(LEN_W), .PFX_W(PFX_W)) u_chk (.*);

// File: tb/dual_issue_arbiter_bench.sv
module dual_issue_arbiter_bench;
  localparam int LEN_W = 4;
  localparam int PFX_W = 3;
  localparam int QB_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, ac1_ready = 1'b0;
  logic [1:0] q_count = '0;
  logic [QB_W-1:0] q_bytes = '0;
  logic [LEN_W-1:0] s0_len = 4'd1, s1_len = 4'd1;
  logic [PFX_W-1:0] s0_pfx = '0, s1_pfx = '0;
  logic s0_asz = 0, s0_osz = 0, s0_disp = 0, s0_imm = 0, s0_pred_taken = 0;
  logic s1_asz = 0, s1_osz = 0, s1_disp = 0, s1_imm = 0;
  logic [7:0] s0_last_byte = 8'h90;
  logic [2:0] s0_cls = '0, s1_cls = '0;
  logic s0_issue, s1_issue, s0_pipe_y, s1_pipe_y, penalty, y_block;

  int checks = 0, failures = 0;
  bit m_hold = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_issue_arbiter #(.LEN_W(LEN_W), .PFX_W(PFX_W), .QB_W(QB_W)) u_dual_issue_arbiter (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ac1_ready(ac1_ready),
    .q_count(q_count), .q_bytes(q_bytes),
    .s0_len(s0_len), .s0_pfx(s0_pfx), .s0_asz(s0_asz), .s0_osz(s0_osz),
    .s0_disp(s0_disp), .s0_imm(s0_imm), .s0_last_byte(s0_last_byte),
    .s0_pred_taken(s0_pred_taken), .s0_cls(s0_cls),
    .s1_len(s1_len), .s1_pfx(s1_pfx), .s1_asz(s1_asz), .s1_osz(s1_osz),
    .s1_disp(s1_disp), .s1_imm(s1_imm), .s1_cls(s1_cls),
    .s0_issue(s0_issue), .s1_issue(s1_issue), .s0_pipe_y(s0_pipe_y),
    .s1_pipe_y(s1_pipe_y), .penalty(penalty), .y_block(y_block)
  );

  // independent restatement of the requirements
  function automatic bit x_lane(logic [2:0] c);
    return c inside {3'd1, 3'd2, 3'd3};
  endfunction

  function automatic bit costly(int p, bit a, bit d, bit o, bit i);
    return (p inside {[2:6]}) || (a && d) || (o && i);
  endfunction

  // called right after a falling edge with inputs already set
  task automatic cyc(string tag);
    bit e0, e1, ep, eb, blocked;
    int l0, l1, qb, p1;
    l0 = int'(s0_len); l1 = int'(s1_len); qb = int'(q_bytes); p1 = int'(s1_pfx);
    e0 = !m_hold && !flush && (q_count != 0);
    blocked = (p1 > 1) || (l0 > 6) || (l0 == 6 && p1 > 0) || (l0 + l1 > qb)
           || (s0_last_byte == 8'h0F && p1 == 0) || s0_pred_taken
           || (s0_cls == 3'd4) || (s1_cls == 3'd4) || x_lane(s1_cls);
    e1 = e0 && (q_count >= 2) && !blocked;
    ep = (e0 && (costly(int'(s0_pfx), s0_asz, s0_disp, s0_osz, s0_imm) || l0 > qb))
      || (e1 && costly(p1, s1_asz, s1_disp, s1_osz, s1_imm));
    eb = m_hold || (e0 && s0_cls == 3'd4);
    #4;
    checks++;
    if (s0_issue !== e0 || s1_issue !== e1 || s0_pipe_y !== 1'b0 ||
        s1_pipe_y !== e1 || penalty !== ep || y_block !== eb) begin
      failures++;
      $display("FAIL %s: issue=%b%b pipe=%b%b pen=%b yb=%b expected issue=%b%b pipe=0%b pen=%b yb=%b",
               tag, s0_issue, s1_issue, s0_pipe_y, s1_pipe_y, penalty, y_block,
               e0, e1, e1, ep, eb);
    end
    @(posedge clk);
    if (m_hold) m_hold = !(ac1_ready || flush);
    else        m_hold = e0 && (s0_cls == 3'd4);
    @(negedge clk);
  endtask

  task automatic neutral();
    q_count = 2'd2; q_bytes = 5'd31; flush = 0; ac1_ready = 1;
    s0_len = 4'd2; s1_len = 4'd2; s0_pfx = '0; s1_pfx = '0;
    {s0_asz, s0_osz, s0_disp, s0_imm, s0_pred_taken} = '0;
    {s1_asz, s1_osz, s1_disp, s1_imm} = '0;
    s0_last_byte = 8'h90; s0_cls = 3'd0; s1_cls = 3'd0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with an empty queue
    neutral(); q_count = 2'd0;
    cyc("R1");

    // R2: queue occupancy 0..3
    for (int c = 0; c < 4; c++) begin
      neutral(); q_count = 2'(c);
      cyc(c == 1 ? "R2" : "R1");
    end

    // R3 R4 R5 R7: lengths, slot-1 prefixes, queue fill
    for (int l0 = 1; l0 < 16; l0++)
      for (int l1 = 1; l1 < 16; l1++)
        for (int p = 0; p < 4; p++)
          for (int q = 0; q < 3; q++) begin
            neutral();
            s0_len = 4'(l0); s1_len = 4'(l1); s1_pfx = 3'(p);
            q_bytes = (q == 0) ? 5'd10 : (q == 1) ? 5'd20 : 5'd31;
            if (p > 1) cyc("R3");
            else if (l0 >= 6) cyc("R4");
            else if (l0 + l1 > int'(q_bytes)) cyc("R5");
            else cyc("R7");
          end

    // R6 R7 R10: class pairs, escape byte, predicted taken
    for (int c0 = 0; c0 < 8; c0++)
      for (int c1 = 0; c1 < 8; c1++)
        for (int v = 0; v < 8; v++) begin
          neutral();
          s0_cls = 3'(c0); s1_cls = 3'(c1);
          s0_pred_taken = v[0];
          s0_last_byte = v[1] ? 8'h0F : 8'h0E;
          s1_pfx = 3'(v[2]);
          if (c0 == 4) cyc("R10");
          else if (v[0] || (v[1] && !v[2])) cyc("R6");
          else cyc("R7");
        end

    // R8 R9: prefix counts and override combinations on both slots
    for (int p0 = 0; p0 < 8; p0++)
      for (int p1 = 0; p1 < 8; p1++)
        for (int f = 0; f < 16; f++)
          for (int k = 0; k < 4; k++) begin
            neutral();
            s0_pfx = 3'(p0); s1_pfx = 3'(p1);
            {s0_asz, s0_disp, s0_osz, s0_imm} = 4'(f);
            {s1_asz, s1_disp, s1_osz, s1_imm} = k[0] ? 4'(15 - f) : 4'(f);
            q_bytes = 5'd10;
            s0_len = k[1] ? 4'd12 : 4'd3;
            if (f != 0 || k[1]) cyc("R9");
            else cyc("R8");
          end

    // R10: exclusive entry held while the address stage stalls
    neutral(); ac1_ready = 0; s0_cls = 3'd4;
    cyc("R10");
    s0_cls = 3'd0;
    for (int i = 0; i < 4; i++) cyc("R10");
    ac1_ready = 1;
    cyc("R10");
    cyc("R10");

    // R11: flush suppresses issue and releases the hold
    neutral(); flush = 1;
    cyc("R11");
    flush = 0; ac1_ready = 0; s0_cls = 3'd4;
    cyc("R10");
    s0_cls = 3'd0;
    cyc("R11");
    flush = 1;
    cyc("R11");
    flush = 0;
    cyc("R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule